// File: doc/BRIEF.md
# Smooth Stereo Attenuator with Soft Mute

This block scales a stereo stream of 16-bit two's-complement samples by a gain held in a 7-bit up/down counter. The gain is never applied at once. A prescaler counts sample strobes, and on every eighth strobe the counter moves one step toward its goal. The goal is the attenuation setting, or zero while soft mute is requested. One slew mechanism therefore serves both volume changes and muting. A full swing from 0 dB to silence takes 127 steps, which is 1016 sample periods.

A counter value of g stands for a gain of g/127. The multiply uses the factor g + (g >> 6) over 128. This makes the top code exactly unity and code 0 exactly zero. A routing stage in front of the multipliers can copy one channel onto both outputs. Outputs are registered on the sample strobe and hold between strobes.

Top module: `smooth_atten`

## Requirements
- R1: While reset is held, and right after it is released, gain_level is 127, out_left and out_right are 0, and out_valid is 0.
- R2: gain_level changes only at the clock edge of a sample strobe. It changes by exactly one step. The steps fall on strobes number 8, 16, 24 and so on, counted from reset.
- R3: On a step strobe the counter moves toward the goal. It rises by 1 if it is below the goal, falls by 1 if it is above the goal, and stays put if it equals the goal. The goal is target_att when mute_req is 0, and 0 when mute_req is 1.
- R4: While mute_req is 1 the counter ramps down to 0 and stays there. When mute_req returns to 0 it ramps back up toward target_att at the same one-step-per-8-strobes rate.
- R5: One clock after a strobe, out_valid is 1 for one cycle. Each output is then sat16(floor((x*m + 64) / 128)), where x is the routed input sample at the strobe, m = g + (g >> 6), and g is the gain_level value just before that strobe's edge.
- R6: When g is 0, both outputs are exactly 0 for any input.
- R7: When g is 127, each output equals its routed input exactly, including -32768 and 32767.
- R8: With mono_en = 1, both outputs carry the right input if mono_right = 1 and the left input if mono_right = 0. With mono_en = 0, left maps to left and right maps to right.
- R9: If target_att changes in the middle of a ramp, the next step already heads toward the new value, starting from the present count.
- R10: Between strobes, out_left and out_right hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe per stereo sample |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| target_att | input | 7 | Attenuation goal, 127 = 0 dB |
| mute_req | input | 1 | Soft mute request, goal forced to 0 |
| mono_en | input | 1 | Copy one channel to both outputs |
| mono_right | input | 1 | Mono source: 1 = right, 0 = left |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| out_valid | output | 1 | Outputs updated this cycle |
| gain_level | output | 7 | Present counter value |

## Verification
The bench tracks the strobe count from reset. A prescaler that is off by one strobe shows up as a gain that steps one strobe early or late. A design that loads the target directly fails in the first strobe after any change. Full-scale inputs at unity gain catch a 1/127 approximation that loses a code or overflows. Inputs at gain zero catch a rounding offset that leaks a nonzero value. A target reversal in the middle of a ramp exposes a counter that keeps its old direction. Mute release exposes a ramp that restarts from the old setting. Mono with each select value catches swapped channel routing.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [1:0] {
    SLEW_HOLD = 2'd0,
    SLEW_UP   = 2'd1,
    SLEW_DOWN = 2'd2
  } slew_e;
endpackage

// File: rtl/gain_slew.sv
module gain_slew
  import atten_pkg::*;
#(
  parameter int GAIN_W   = 7,
  parameter int STEP_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [GAIN_W-1:0] target,
  input  logic              mute_req,
  output logic [GAIN_W-1:0] gain
);
  localparam int PRE_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_DIV - 1);
  localparam logic [GAIN_W-1:0] GAIN_FULL = {GAIN_W{1'b1}};

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic [GAIN_W-1:0] goal;
  logic              step_now;
  slew_e             dir;

  always_comb begin
    goal     = mute_req ? '0 : target;
    step_now = (pre_q == PRE_LAST);
    pre_d    = step_now ? '0 : pre_q + PRE_W'(1);
    if (gain_q < goal)      dir = SLEW_UP;
    else if (gain_q > goal) dir = SLEW_DOWN;
    else                    dir = SLEW_HOLD;
    gain_d = gain_q;
    if (step_now) begin
      case (dir)
        SLEW_UP:   gain_d = gain_q + GAIN_W'(1);
        SLEW_DOWN: gain_d = gain_q - GAIN_W'(1);
        default:   gain_d = gain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      gain_q <= GAIN_FULL;
    end else if (smp_valid) begin
      pre_q  <= pre_d;
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/chan_route.sv
module chan_route #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              mono_en,
  input  logic              mono_right,
  output logic [DATA_W-1:0] rt_left,
  output logic [DATA_W-1:0] rt_right
);
  logic [DATA_W-1:0] mono_src;

  always_comb begin
    mono_src = mono_right ? in_right : in_left;
    if (mono_en) begin
      rt_left  = mono_src;
      rt_right = mono_src;
    end else begin
      rt_left  = in_left;
      rt_right = in_right;
    end
  end
endmodule

// File: rtl/gain_mult.sv
module gain_mult #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 7
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] scaled
);
  localparam int MW = GAIN_W + 1;
  localparam int PW = DATA_W + MW + 1;
  localparam logic signed [PW-1:0] SAT_HI = PW'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - PW'(1);
  localparam logic signed [PW-1:0] RND    = PW'(1) << (GAIN_W - 1);

  logic [MW-1:0]          mul_k;
  logic signed [PW-1:0]   x_ext, k_ext, prod, rnd, shr;

  always_comb begin
    mul_k  = {1'b0, gain} + MW'(gain >> (GAIN_W - 1));
    x_ext  = $signed({{(PW - DATA_W){sample[DATA_W-1]}}, sample});
    k_ext  = $signed({{(PW - MW){1'b0}}, mul_k});
    prod   = x_ext * k_ext;
    rnd    = prod + RND;
    shr    = rnd >>> GAIN_W;
    if (shr > SAT_HI)      scaled = SAT_HI[DATA_W-1:0];
    else if (shr < SAT_LO) scaled = SAT_LO[DATA_W-1:0];
    else                   scaled = shr[DATA_W-1:0];
  end
endmodule

// File: rtl/smooth_atten.sv
module smooth_atten #(
  parameter int DATA_W   = 16,
  parameter int GAIN_W   = 7,
  parameter int STEP_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [GAIN_W-1:0] target_att,
  input  logic              mute_req,
  input  logic              mono_en,
  input  logic              mono_right,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              out_valid,
  output logic [GAIN_W-1:0] gain_level
);
  localparam int NCH = 2;

  logic [NCH-1:0][DATA_W-1:0] routed, scaled, out_q, out_d;
  logic                       vld_q;

  gain_slew #(.GAIN_W(GAIN_W), .STEP_DIV(STEP_DIV)) u_slew (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .target(target_att), .mute_req(mute_req), .gain(gain_level)
  );

  chan_route #(.DATA_W(DATA_W)) u_route (
    .in_left(in_left), .in_right(in_right),
    .mono_en(mono_en), .mono_right(mono_right),
    .rt_left(routed[0]), .rt_right(routed[1])
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    gain_mult #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_mult (
      .sample(routed[ch]), .gain(gain_level), .scaled(scaled[ch])
    );
  end

  always_comb begin
    out_d = smp_valid ? scaled : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= smp_valid;
    end
  end

  assign out_left  = out_q[0];
  assign out_right = out_q[1];
  assign out_valid = vld_q;
endmodule

// File: rtl/atten_chk.sv
module atten_chk #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [GAIN_W-1:0] target_att,
  input logic              mute_req,
  input logic              mono_en,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              out_valid,
  input logic [GAIN_W-1:0] gain_level
);
  assert_gain_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_level != $past(gain_level)) |-> $past(smp_valid));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_level != $past(gain_level)) |->
      ((gain_level == $past(gain_level) + GAIN_W'(1)) ||
       (gain_level == $past(gain_level) - GAIN_W'(1))));

  assert_up_toward_goal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_level > $past(gain_level)) |->
      (!$past(mute_req) && ($past(target_att) > $past(gain_level))));

  assert_down_toward_goal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_level < $past(gain_level)) |->
      ($past(mute_req) || ($past(target_att) < $past(gain_level))));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(smp_valid));

  assert_zero_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(gain_level) == '0)) |-> (out_left == '0 && out_right == '0));

  assert_mono_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mono_en)) |-> (out_left == out_right));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> ($stable(out_left) && $stable(out_right)));
endmodule

bind smooth_atten atten_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .target_att(target_att),
  .mute_req(mute_req), .mono_en(mono_en), .out_left(out_left),
  .out_right(out_right), .out_valid(out_valid), .gain_level(gain_level)
);

// File: tb/smooth_atten_tb.sv
`timescale 1ns/1ps
module smooth_atten_tb;
  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] in_left, in_right;
  logic [6:0]  target_att;
  logic        mute_req, mono_en, mono_right;
  logic [15:0] out_left, out_right;
  logic        out_valid;
  logic [6:0]  gain_level;

  int vectors = 0;
  int errors  = 0;
  int mg, mpre;
  bit done = 0;

  smooth_atten u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .in_left(in_left), .in_right(in_right), .target_att(target_att),
    .mute_req(mute_req), .mono_en(mono_en), .mono_right(mono_right),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
    .gain_level(gain_level)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int scale(int x, int g);
    int m, y;
    m = g + (g >> 6);
    y = (x * m + 64) >>> 7;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic strobe(string tag, int l, int r, bit do_chk);
    int sl, sr, el, er, goal;
    @(negedge clk);
    in_left = 16'(l); in_right = 16'(r); smp_valid = 1;
    sl = mono_en ? (mono_right ? r : l) : l;
    sr = mono_en ? (mono_right ? r : l) : r;
    el = scale(sl, mg); er = scale(sr, mg);
    goal = mute_req ? 0 : int'(target_att);
    if (mpre == 7) begin
      if (mg < goal) mg++;
      else if (mg > goal) mg--;
    end
    mpre = (mpre + 1) % 8;
    @(negedge clk);
    smp_valid = 0;
    if (do_chk) begin
      check(tag, "out_left", int'($signed(out_left)), el);
      check(tag, "out_right", int'($signed(out_right)), er);
      check(tag, "gain_level", int'(gain_level), mg);
      check(tag, "out_valid", int'(out_valid), 1);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; smp_valid = 0; in_left = 0; in_right = 0;
    target_att = 127; mute_req = 0; mono_en = 0; mono_right = 0;
    mg = 127; mpre = 0;
    repeat (3) @(negedge clk);
    check("R1", "gain_level in reset", int'(gain_level), 127);
    check("R1", "out_left in reset", int'(out_left), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "gain_level after reset", int'(gain_level), 127);
    check("R1", "out_right after reset", int'(out_right), 0);
    check("R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_unity();
    strobe("R7", 32767, -32768, 1);
    strobe("R7", -1, 1, 1);
    strobe("R7", 12345, -23456, 1);
    check("R7", "unity left", int'($signed(out_left)), 12345);
  endtask

  task automatic t_hold();
    int hl, hr;
    strobe("R10", 1000, -2000, 1);
    hl = int'($signed(out_left)); hr = int'($signed(out_right));
    repeat (5) @(negedge clk);
    check("R10", "held left", int'($signed(out_left)), hl);
    check("R10", "held right", int'($signed(out_right)), hr);
    check("R10", "out_valid idle", int'(out_valid), 0);
  endtask

  task automatic t_ramp_down();
    target_att = 120;
    for (int i = 0; i < 40; i++) strobe("R2", 20000 - i * 731, i * 997 - 15000, 1);
    check("R3", "gain after ramp", int'(gain_level), mg);
  endtask

  task automatic t_turn();
    target_att = 100;
    for (int i = 0; i < 20; i++) strobe("R3", 30000, -30000, 1);
    target_att = 124;
    for (int i = 0; i < 40; i++) strobe("R9", -7777, 7777, 1);
  endtask

  task automatic t_mute();
    mute_req = 1;
    for (int i = 0; i < 1040; i++) strobe("R4", 25000, -25000, (i % 16) == 0);
    check("R4", "gain muted", int'(gain_level), 0);
    strobe("R6", 32767, -32768, 1);
    check("R6", "muted left zero", int'(out_left), 0);
    check("R6", "muted right zero", int'(out_right), 0);
    mute_req = 0;
    for (int i = 0; i < 80; i++) strobe("R4", 16000, -16000, 1);
    check("R4", "release gain", int'(gain_level), 10);
  endtask

  task automatic t_mono();
    target_att = int'(gain_level);
    mono_en = 1; mono_right = 1;
    strobe("R8", 111, 22222, 1);
    mono_right = 0;
    strobe("R8", 111, 22222, 1);
    mono_en = 0;
    strobe("R8", 111, 22222, 1);
  endtask

  initial begin
    t_reset();
    t_unity();
    t_hold();
    t_ramp_down();
    t_turn();
    t_mute();
    t_mono();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule